// File: doc/BRIEF.md
# Duty-Cycled Address Gate with Word Budget

This block sits in the read-address and write-address paths between an AXI4 manager and its subordinate. It shapes traffic in two ways. A repeating period of `cfg_on_cycles + cfg_off_cycles` clock cycles opens the gate for the first `cfg_on_cycles` cycles and closes it for the rest. A per-period budget of 64-bit data words, `cfg_word_cap`, can also close it early. Each burst is charged against the budget when its address is accepted, so data beats never have to be stalled.

Gating acts on the handshake wires only. A channel is passed by raising `m_*_valid` toward the subordinate and `s_*_ready` toward the manager together. It is blocked by holding both low. Address and length always flow straight through. The pass/block decision for a cycle depends only on registered state and on the inputs of that same cycle, so a handshake that completes in a cycle is never cut short within that cycle. The read and write channels share one budget. When both ask in the same cycle, the read request is served first.

Top module: `pulse_bw_gate`

## Requirements
- R1: After reset, the period position is 0. In each period, positions 0 to `cfg_on_cycles`-1 are open. An open cycle with budget left sets `m_x_valid = s_x_valid` and `s_x_ready = m_x_ready` on both channels.
- R2: Positions `cfg_on_cycles` to `cfg_on_cycles+cfg_off_cycles-1` are closed. In those cycles `m_ar_valid`, `s_ar_ready`, `m_aw_valid` and `s_aw_ready` are all 0.
- R3: A burst of length field L costs (L+1)×(DATA_W/64) words. It is passed only if the words already used in this period plus that cost do not exceed `cfg_word_cap`. A burst that does not fit has valid and ready held low.
- R4: With `cfg_word_cap` = 0 there is no budget limit. The ledger stays at zero.
- R5: The used-word ledger returns to zero on the first cycle of every period. With 320 on, 80 off, a cap of 50 and 8-beat bursts offered continuously, exactly 6 bursts pass per period.
- R6: With both lengths 0 the gate is open on every cycle. The budget then reloads every cycle, so the cap limits words per cycle.
- R7: When both channels request in one cycle, the read cost is reserved first. The write passes only if the used words plus both costs fit within the cap.
- R8: With `cfg_on_cycles` = 0 and `cfg_off_cycles` > 0 no address is ever passed.
- R9: `m_ar_addr`/`m_ar_len` equal `s_ar_addr`/`s_ar_len` on every cycle, and likewise for the write channel.
- R10: On each channel, a handshake on the manager side happens in exactly the cycles in which one happens on the subordinate side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_on_cycles | input | CNT_W | Open-phase length in cycles |
| cfg_off_cycles | input | CNT_W | Closed-phase length in cycles |
| cfg_word_cap | input | CAP_W | 64-bit words allowed per period, 0 = unlimited |
| s_ar_valid | input | 1 | Read address valid from manager |
| s_ar_ready | output | 1 | Read address ready to manager |
| s_ar_addr | input | ADDR_W | Read address from manager |
| s_ar_len | input | LEN_W | Read burst length field from manager |
| m_ar_valid | output | 1 | Read address valid to subordinate |
| m_ar_ready | input | 1 | Read address ready from subordinate |
| m_ar_addr | output | ADDR_W | Read address to subordinate |
| m_ar_len | output | LEN_W | Read burst length field to subordinate |
| s_aw_valid | input | 1 | Write address valid from manager |
| s_aw_ready | output | 1 | Write address ready to manager |
| s_aw_addr | input | ADDR_W | Write address from manager |
| s_aw_len | input | LEN_W | Write burst length field from manager |
| m_aw_valid | output | 1 | Write address valid to subordinate |
| m_aw_ready | input | 1 | Write address ready from subordinate |
| m_aw_addr | output | ADDR_W | Write address to subordinate |
| m_aw_len | output | LEN_W | Write burst length field to subordinate |

## Verification
Two events can land in the same cycle. The first is a read and a write request both drawing on the shared word budget. The second is a charge being made on the last cycle of a period, in the very cycle the ledger is due to reload. The first is provoked by holding both valids high with cost pairs that fit jointly and that fit only one at a time. The bench then judges that the read side alone is granted when the pair does not fit. The second is provoked with a zero closed phase and with both lengths zero, where the reload falls on an open cycle. The bench judges that the next period starts with its full budget.

// File: rtl/pulse_bw_pkg.sv
package pulse_bw_pkg;

  typedef logic [31:0] word_t;

  // words charged for one burst: (length field + 1) beats times words per beat
  function automatic word_t burst_charge(input word_t len_field, input word_t words_per_beat);
    return (len_field + 32'd1) * words_per_beat;
  endfunction

  // cap of zero disables the limit
  function automatic logic budget_fits(input word_t used, input word_t held,
                                       input word_t charge, input word_t cap);
    return (cap == 32'd0) || ((used + held + charge) <= cap);
  endfunction

endpackage

// File: rtl/pbg_period_timer.sv
module pbg_period_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] on_cycles,
  input  logic [CNT_W-1:0] off_cycles,
  output logic             gate_open,
  output logic             period_wrap
);
  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] period_len;
  logic [SUM_W-1:0] pos_q;
  logic [SUM_W-1:0] pos_inc;

  assign period_len  = {1'b0, on_cycles} + {1'b0, off_cycles};
  assign pos_inc     = pos_q + 1'b1;
  assign period_wrap = (pos_inc >= period_len);
  assign gate_open   = (period_len == '0) || (pos_q < {1'b0, on_cycles});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos_q <= '0;
    end else if (period_wrap) begin
      pos_q <= '0;
    end else begin
      pos_q <= pos_inc;
    end
  end

endmodule

// File: rtl/pbg_word_ledger.sv
module pbg_word_ledger
  import pulse_bw_pkg::*;
#(
  parameter int LEN_W = 8,
  parameter int CAP_W = 16,
  parameter int WPB   = 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [CAP_W-1:0] cap,
  input  logic [LEN_W-1:0] ar_len,
  input  logic [LEN_W-1:0] aw_len,
  input  logic             ar_req,
  input  logic             aw_req,
  input  logic             ar_take,
  input  logic             aw_take,
  input  logic             period_wrap,
  output word_t            ar_charge,
  output word_t            aw_charge,
  output logic             ar_fit,
  output logic             aw_fit,
  output logic [CAP_W-1:0] used_q
);
  word_t            used_w;
  word_t            cap_w;
  word_t            ar_held;
  logic [CAP_W-1:0] spend;
  logic             aw_seen;

  generate
    if (WPB == 1) begin : g_unit_beat
      assign ar_charge = word_t'(ar_len) + 32'd1;
      assign aw_charge = word_t'(aw_len) + 32'd1;
    end else begin : g_wide_beat
      assign ar_charge = burst_charge(word_t'(ar_len), word_t'(WPB));
      assign aw_charge = burst_charge(word_t'(aw_len), word_t'(WPB));
    end
  endgenerate

  assign used_w  = word_t'(used_q);
  assign cap_w   = word_t'(cap);
  assign ar_fit  = budget_fits(used_w, 32'd0, ar_charge, cap_w);
  assign ar_held = (ar_req && ar_fit) ? ar_charge : 32'd0;
  assign aw_fit  = budget_fits(used_w, ar_held, aw_charge, cap_w);
  assign aw_seen = aw_req;

  assign spend = (ar_take ? ar_charge[CAP_W-1:0] : '0)
               + ((aw_take && aw_seen) ? aw_charge[CAP_W-1:0] : '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      used_q <= '0;
    end else if (period_wrap || (cap == '0)) begin
      used_q <= '0;
    end else begin
      used_q <= used_q + spend;
    end
  end

endmodule

// File: rtl/pbg_chan_gate.sv
module pbg_chan_gate #(
  parameter int PAY_W = 40
) (
  input  logic             s_valid,
  output logic             s_ready,
  input  logic [PAY_W-1:0] s_pay,
  output logic             m_valid,
  input  logic             m_ready,
  output logic [PAY_W-1:0] m_pay,
  input  logic             pass,
  output logic             take
);
  assign m_valid = s_valid && pass;
  assign s_ready = m_ready && pass;
  assign m_pay   = s_pay;
  assign take    = m_valid && m_ready;
endmodule

// File: rtl/pulse_bw_gate.sv
module pulse_bw_gate
  import pulse_bw_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int LEN_W  = 8,
  parameter int CNT_W  = 16,
  parameter int CAP_W  = 16,
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CNT_W-1:0]  cfg_on_cycles,
  input  logic [CNT_W-1:0]  cfg_off_cycles,
  input  logic [CAP_W-1:0]  cfg_word_cap,
  input  logic              s_ar_valid,
  output logic              s_ar_ready,
  input  logic [ADDR_W-1:0] s_ar_addr,
  input  logic [LEN_W-1:0]  s_ar_len,
  output logic              m_ar_valid,
  input  logic              m_ar_ready,
  output logic [ADDR_W-1:0] m_ar_addr,
  output logic [LEN_W-1:0]  m_ar_len,
  input  logic              s_aw_valid,
  output logic              s_aw_ready,
  input  logic [ADDR_W-1:0] s_aw_addr,
  input  logic [LEN_W-1:0]  s_aw_len,
  output logic              m_aw_valid,
  input  logic              m_aw_ready,
  output logic [ADDR_W-1:0] m_aw_addr,
  output logic [LEN_W-1:0]  m_aw_len
);
  localparam int WORD_W = 64;
  localparam int WPB    = (DATA_W >= WORD_W) ? (DATA_W / WORD_W) : 1;
  localparam int PAY_W  = ADDR_W + LEN_W;

  logic             gate_open;
  logic             period_wrap;
  logic             ar_fit;
  logic             aw_fit;
  logic             ar_take;
  logic             aw_take;
  word_t            ar_charge;
  word_t            aw_charge;
  logic [CAP_W-1:0] ledger_used;

  pbg_period_timer #(.CNT_W(CNT_W)) timer_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .on_cycles  (cfg_on_cycles),
    .off_cycles (cfg_off_cycles),
    .gate_open  (gate_open),
    .period_wrap(period_wrap)
  );

  pbg_word_ledger #(.LEN_W(LEN_W), .CAP_W(CAP_W), .WPB(WPB)) ledger_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .cap        (cfg_word_cap),
    .ar_len     (s_ar_len),
    .aw_len     (s_aw_len),
    .ar_req     (s_ar_valid),
    .aw_req     (s_aw_valid),
    .ar_take    (ar_take),
    .aw_take    (aw_take),
    .period_wrap(period_wrap),
    .ar_charge  (ar_charge),
    .aw_charge  (aw_charge),
    .ar_fit     (ar_fit),
    .aw_fit     (aw_fit),
    .used_q     (ledger_used)
  );

  pbg_chan_gate #(.PAY_W(PAY_W)) ar_gate_i (
    .s_valid(s_ar_valid),
    .s_ready(s_ar_ready),
    .s_pay  ({s_ar_addr, s_ar_len}),
    .m_valid(m_ar_valid),
    .m_ready(m_ar_ready),
    .m_pay  ({m_ar_addr, m_ar_len}),
    .pass   (gate_open && ar_fit),
    .take   (ar_take)
  );

  pbg_chan_gate #(.PAY_W(PAY_W)) aw_gate_i (
    .s_valid(s_aw_valid),
    .s_ready(s_aw_ready),
    .s_pay  ({s_aw_addr, s_aw_len}),
    .m_valid(m_aw_valid),
    .m_ready(m_aw_ready),
    .m_pay  ({m_aw_addr, m_aw_len}),
    .pass   (gate_open && aw_fit),
    .take   (aw_take)
  );

endmodule

// File: rtl/pbg_checker.sv
module pbg_checker
  import pulse_bw_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int CAP_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic [CNT_W-1:0] cfg_on_cycles,
  input logic [CNT_W-1:0] cfg_off_cycles,
  input logic [CAP_W-1:0] cfg_word_cap,
  input logic             s_ar_valid,
  input logic             s_ar_ready,
  input logic             m_ar_valid,
  input logic             m_ar_ready,
  input logic             s_aw_valid,
  input logic             s_aw_ready,
  input logic             m_aw_valid,
  input logic             m_aw_ready,
  input logic             gate_open,
  input logic             period_wrap,
  input logic [CAP_W-1:0] ledger_used,
  input word_t            ar_charge,
  input word_t            aw_charge,
  input logic             ar_take,
  input logic             aw_take
);
  // R2
  closed_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate_open |-> (!m_ar_valid && !s_ar_ready && !m_aw_valid && !s_aw_ready));

  // R3
  cap_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_cap != '0 && ledger_used <= cfg_word_cap) |=> (ledger_used <= $past(cfg_word_cap)));

  // R4
  no_cap_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_cap == '0 && gate_open && s_ar_valid) |-> m_ar_valid);

  // R5
  reload_chk: assert property (@(posedge clk) disable iff (!rst_n)
    period_wrap |=> (ledger_used == '0));

  // R6
  always_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_on_cycles == '0 && cfg_off_cycles == '0) |-> gate_open);

  // R7
  joint_fit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_word_cap != '0 && ar_take && aw_take) |->
      ((word_t'(ledger_used) + ar_charge + aw_charge) <= word_t'(cfg_word_cap)));

  // R8
  never_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_on_cycles == '0 && cfg_off_cycles != '0) |-> (!m_ar_valid && !m_aw_valid));

  // R10
  ar_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_ar_valid && s_ar_ready) == (m_ar_valid && m_ar_ready));

  // R10
  aw_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (s_aw_valid && s_aw_ready) == (m_aw_valid && m_aw_ready));

endmodule

bind pulse_bw_gate pbg_checker #(.CNT_W(CNT_W), .CAP_W(CAP_W)) chk_i (
  .clk           (clk),
  .rst_n         (rst_n),
  .cfg_on_cycles (cfg_on_cycles),
  .cfg_off_cycles(cfg_off_cycles),
  .cfg_word_cap  (cfg_word_cap),
  .s_ar_valid    (s_ar_valid),
  .s_ar_ready    (s_ar_ready),
  .m_ar_valid    (m_ar_valid),
  .m_ar_ready    (m_ar_ready),
  .s_aw_valid    (s_aw_valid),
  .s_aw_ready    (s_aw_ready),
  .m_aw_valid    (m_aw_valid),
  .m_aw_ready    (m_aw_ready),
  .gate_open     (gate_open),
  .period_wrap   (period_wrap),
  .ledger_used   (ledger_used),
  .ar_charge     (ar_charge),
  .aw_charge     (aw_charge),
  .ar_take       (ar_take),
  .aw_take       (aw_take)
);

// File: tb/pulse_bw_gate_tb_top.sv
module pulse_bw_gate_tb_top;
  timeunit 1ns;
  timeprecision 100ps;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] cfg_on = '0, cfg_off = '0, cfg_cap = '0;
  logic        s_ar_valid = 1'b0, m_ar_ready = 1'b0, s_aw_valid = 1'b0, m_aw_ready = 1'b0;
  logic [31:0] s_ar_addr = '0, s_aw_addr = '0;
  logic [7:0]  s_ar_len = '0, s_aw_len = '0;
  logic        s_ar_ready, m_ar_valid, s_aw_ready, m_aw_valid;
  logic [31:0] m_ar_addr, m_aw_addr;
  logic [7:0]  m_ar_len, m_aw_len;

  // staged stimulus, applied at the next falling edge
  logic        nx_arv = 0, nx_arr = 0, nx_awv = 0, nx_awr = 0;
  logic [31:0] nx_ara = 0, nx_awa = 0;
  logic [7:0]  nx_arl = 0, nx_awl = 0;

  int    n_cmp = 0, n_bad = 0;
  bit    done = 0;
  int    m_pos = 0, m_used = 0;
  int    acc_ar = 0, acc_aw = 0;
  string tag = "R1";

  always #2.5 clk = ~clk;

  pulse_bw_gate dut_i (
    .clk(clk), .rst_n(rst_n),
    .cfg_on_cycles(cfg_on), .cfg_off_cycles(cfg_off), .cfg_word_cap(cfg_cap),
    .s_ar_valid(s_ar_valid), .s_ar_ready(s_ar_ready), .s_ar_addr(s_ar_addr), .s_ar_len(s_ar_len),
    .m_ar_valid(m_ar_valid), .m_ar_ready(m_ar_ready), .m_ar_addr(m_ar_addr), .m_ar_len(m_ar_len),
    .s_aw_valid(s_aw_valid), .s_aw_ready(s_aw_ready), .s_aw_addr(s_aw_addr), .s_aw_len(s_aw_len),
    .m_aw_valid(m_aw_valid), .m_aw_ready(m_aw_ready), .m_aw_addr(m_aw_addr), .m_aw_len(m_aw_len)
  );

  task automatic chk(input logic got, input logic exp, input string t, input string what);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0b expected %0b (pos %0d used %0d)", t, what, got, exp, m_pos, m_used);
    end
  endtask

  task automatic chk_int(input int got, input int exp, input string t, input string what);
    n_cmp++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0d expected %0d", t, what, got, exp);
    end
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
  endtask

  task automatic stage(input logic arv, input logic arr, input logic [7:0] arl,
                       input logic awv, input logic awr, input logic [7:0] awl);
    nx_arv = arv; nx_arr = arr; nx_arl = arl;
    nx_awv = awv; nx_awr = awr; nx_awl = awl;
    nx_ara = $urandom; nx_awa = $urandom;
  endtask

  // one cycle: apply inputs, compare against the reference, advance the reference
  task automatic step();
    int  per, ca, cw, held, spend;
    bit  open, fa, fw, ev_ar, er_ar, ev_aw, er_aw;
    @(negedge clk);
    s_ar_valid = nx_arv; m_ar_ready = nx_arr; s_ar_len = nx_arl; s_ar_addr = nx_ara;
    s_aw_valid = nx_awv; m_aw_ready = nx_awr; s_aw_len = nx_awl; s_aw_addr = nx_awa;
    #1;
    per   = int'(cfg_on) + int'(cfg_off);
    open  = (per == 0) || (m_pos < int'(cfg_on));
    ca    = int'(s_ar_len) + 1;
    cw    = int'(s_aw_len) + 1;
    fa    = (cfg_cap == 0) || (m_used + ca <= int'(cfg_cap));
    held  = (s_ar_valid && fa) ? ca : 0;
    fw    = (cfg_cap == 0) || (m_used + held + cw <= int'(cfg_cap));
    ev_ar = s_ar_valid && open && fa;
    er_ar = m_ar_ready && open && fa;
    ev_aw = s_aw_valid && open && fw;
    er_aw = m_aw_ready && open && fw;
    chk(m_ar_valid, ev_ar, tag, "m_ar_valid");
    chk(s_ar_ready, er_ar, tag, "s_ar_ready");
    chk(m_aw_valid, ev_aw, tag, "m_aw_valid");
    chk(s_aw_ready, er_aw, tag, "s_aw_ready");
    chk(m_ar_addr == s_ar_addr && m_ar_len == s_ar_len, 1'b1, "R9", "read payload");
    chk(m_aw_addr == s_aw_addr && m_aw_len == s_aw_len, 1'b1, "R9", "write payload");
    chk(s_ar_valid && s_ar_ready, m_ar_valid && m_ar_ready, "R10", "read handshake pairing");
    chk(s_aw_valid && s_aw_ready, m_aw_valid && m_aw_ready, "R10", "write handshake pairing");
    if (m_ar_valid && m_ar_ready) acc_ar++;
    if (m_aw_valid && m_aw_ready) acc_aw++;
    spend = ((ev_ar && m_ar_ready) ? ca : 0) + ((ev_aw && m_aw_ready) ? cw : 0);
    if (m_pos + 1 >= per) begin
      m_pos = 0; m_used = 0;
    end else begin
      m_pos++;
      m_used = (cfg_cap == 0) ? 0 : m_used + spend;
    end
  endtask

  task automatic do_reset(input int on, input int off, input int cap);
    rst_n = 1'b0;
    s_ar_valid = 0; m_ar_ready = 0; s_aw_valid = 0; m_aw_ready = 0;
    cfg_on = on[15:0]; cfg_off = off[15:0]; cfg_cap = cap[15:0];
    repeat (2) @(posedge clk);
    @(negedge clk); #1;
    chk(m_ar_valid | s_ar_ready | m_aw_valid | s_aw_ready, 1'b0, "R1", "handshakes during reset");
    @(posedge clk); #0.5;
    rst_n = 1'b1;
    m_pos = 0; m_used = 0; acc_ar = 0; acc_aw = 0;
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      summary();
      $finish;
    end
  end

  initial begin
    // R1 / R2: 10 open, 5 closed, unlimited budget
    tag = "R2";
    do_reset(10, 5, 0);
    stage(1, 1, 0, 0, 0, 0);
    run(45);
    chk_int(acc_ar, 30, "R1", "reads passed over three periods");

    // R3 / R5: 320 open, 80 closed, 50 words, 8-beat reads
    tag = "R3";
    do_reset(320, 80, 50);
    stage(1, 1, 7, 0, 0, 0);
    run(800);
    chk_int(acc_ar, 12, "R5", "8-beat reads over two periods");

    // R4: unlimited budget with maximal bursts
    tag = "R4";
    do_reset(4, 4, 0);
    stage(1, 1, 255, 1, 1, 255);
    run(16);
    chk_int(acc_ar, 8, "R4", "reads with no cap");
    chk_int(acc_aw, 8, "R4", "writes with no cap");

    // R6: both lengths zero, per-cycle budget of 8
    tag = "R6";
    do_reset(0, 0, 8);
    stage(1, 1, 3, 1, 1, 3);
    run(20);
    chk_int(acc_ar, 20, "R6", "reads every cycle");
    chk_int(acc_aw, 20, "R6", "writes every cycle, joint fit");
    do_reset(0, 0, 8);
    stage(1, 1, 4, 1, 1, 4);
    run(20);
    chk_int(acc_ar, 20, "R7", "reads win per-cycle budget");
    chk_int(acc_aw, 0, "R7", "writes starved when pair does not fit");

    // R7: shared budget, zero closed phase so reload lands on an open cycle
    tag = "R7";
    do_reset(20, 0, 10);
    stage(1, 1, 5, 1, 1, 3);
    run(40);
    chk_int(acc_ar, 2, "R7", "reads with jointly fitting pair");
    chk_int(acc_aw, 2, "R7", "writes with jointly fitting pair");
    do_reset(20, 0, 10);
    stage(1, 1, 5, 1, 1, 4);
    run(40);
    chk_int(acc_ar, 2, "R7", "reads when pair overflows");
    chk_int(acc_aw, 0, "R7", "writes when pair overflows");

    // R8: never open
    tag = "R8";
    do_reset(0, 7, 0);
    stage(1, 1, 0, 1, 1, 0);
    run(30);
    chk_int(acc_ar + acc_aw, 0, "R8", "addresses passed with zero open length");

    // mixed traffic against the reference model
    tag = "R3";
    for (int r = 0; r < 10; r++) begin
      do_reset(int'($urandom_range(0, 12)), int'($urandom_range(0, 12)), int'($urandom_range(0, 40)));
      for (int i = 0; i < 300; i++) begin
        stage(1'($urandom), 1'($urandom), 8'($urandom_range(0, 15)),
              1'($urandom), 1'($urandom), 8'($urandom_range(0, 15)));
        step();
      end
    end

    done = 1;
    summary();
    $finish;
  end

endmodule